// File: doc/BRIEF.md
# CompactFlash Card Presence and Host Mode Control

This block watches the two active-low card-detect pins of a CompactFlash socket and decides whether a card is fully seated. A card counts as present only when both pins read low. Any other combination is taken as an empty or partly inserted socket. Both pins pass through a two-flop synchroniser and then a stable-interval filter. The filtered presence changes only after the raw combination has disagreed with it for `DEBOUNCE` consecutive cycles. Each change of filtered presence, in either direction, produces a one-cycle event and sets a sticky status flag.

The block also holds the host mode word. This word carries the interface mode, the card type, card reset, host enable, output tristate, the two DMA enables and the DRQ block size. The card reset output is taken straight from its register bit, so software times the reset pulse by writing the bit high and later low. Writing host enable from 0 to 1 raises a one-cycle soft reset for the transfer datapath, which aborts any transfer in progress. Software reaches both words through a simple word-addressed write/read port with registered read data.

Top module: `cf_presence_ctrl`

## Requirements
- R1: After reset, card_rst is 1, host_en is 0, card_present, detect_evt and dp_soft_rst are 0, the mode word (word address 3) reads 0x0000_0008, and with both detect pins high the status word (word address 0) reads 0x0000_000C.
- R2: Filtered presence can become 1 only when cd1_n and cd2_n are both low. If one pin is low and the other high, card_present stays 0 however long that lasts.
- R3: A detect-pin change reaches card_present exactly DEBOUNCE+2 clock edges after it is applied: two edges of synchronisation and DEBOUNCE edges of filtering. A disagreement that lasts fewer than DEBOUNCE synchronised cycles leaves card_present unchanged and raises no event.
- R4: detect_evt is high for exactly one cycle, on the edge where card_present changes, for both insertion and removal. The same edge sets status bit 0.
- R5: Status bit 0 stays set until a write to the status word with data bit 0 set. A write with bit 0 clear leaves it set. The other status bits ignore writes.
- R6: Status fields: bit 0 presence-change flag, bit 1 reads 0, bit 2 synchronised cd1_n, bit 3 synchronised cd2_n, bit 4 card_ack, bit 5 card_rdy, bit 6 card_iordy, bit 7 card_io16, bit 8 filtered presence, bits 31:9 read 0. Pin levels appear two edges after they change.
- R7: Mode word fields: bits 1:0 mode (0 memory, 1 I/O, 2 true-IDE), bit 2 card type (1 = CF+), bit 3 card reset, bit 4 host enable, bit 5 output tristate, bit 8 Ultra DMA enable, bit 9 multiword DMA enable, bits 12:11 DRQ block size (0..3 = 512..4096 bytes). All other bits read 0, so writing all ones reads back 0x0000_1B3F. The outputs take a written value on the write edge, and the word holds when it is not written.
- R8: card_rst equals mode bit 3 and follows each write of that bit on the write edge, with no added delay or stretching.
- R9: dp_soft_rst is a one-cycle pulse on the edge where a write takes host enable from 0 to 1. Writing host enable as 1 while it is already 1 produces no pulse.
- R10: Reads of word addresses other than 0 and 3 return 0. Writes to them change neither word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| cd1_n | input | 1 | Card detect pin 1, active low |
| cd2_n | input | 1 | Card detect pin 2, active low |
| card_ack | input | 1 | Card input-acknowledge level |
| card_rdy | input | 1 | Card ready level |
| card_iordy | input | 1 | Card I/O ready level |
| card_io16 | input | 1 | Card 16-bit I/O port select level |
| card_present | output | 1 | Filtered presence |
| detect_evt | output | 1 | One-cycle presence-change event |
| card_rst | output | 1 | Card reset drive |
| card_hiz | output | 1 | Tristate request for card-side outputs |
| host_en | output | 1 | Host enable |
| dp_soft_rst | output | 1 | One-cycle datapath soft reset |
| mode_sel | output | 2 | Interface mode |
| card_plus | output | 1 | Card type is CF+ |
| udma_en | output | 1 | Ultra DMA enable |
| mwdma_en | output | 1 | Multiword DMA enable |
| drq_size | output | 2 | DRQ block size code |

## Verification
Mode outputs, card_rst and dp_soft_rst change on the write edge, so the bench samples them at the falling edge straight after the write. Read data is registered, so the scoreboard's monitor compares a read one edge after the strobe. Pin levels in the status word appear two edges after they are driven. Filtered presence moves exactly DEBOUNCE+2 edges after a pin change. The bench therefore checks card_present on the edge before that point and on that point, and it counts detect_evt pulses across the whole window. This shows that exactly one event occurs and that a short glitch produces none.

// File: rtl/cf_ctl_pkg.sv
package cf_ctl_pkg;
  localparam int REG_DW  = 32;
  localparam int STAT_WA = 0;
  localparam int MODE_WA = 3;

  // mode word bit positions
  localparam int MB_TYPE  = 2;
  localparam int MB_CRST  = 3;
  localparam int MB_HEN   = 4;
  localparam int MB_HIZ   = 5;
  localparam int MB_UDMA  = 8;
  localparam int MB_MWDMA = 9;
  localparam int MB_DRQ   = 11;

  localparam logic [REG_DW-1:0] MODE_WMASK = 32'h0000_1B3F;
  localparam logic [REG_DW-1:0] MODE_RST   = 32'h0000_0008;

  // synchroniser lane order
  localparam int SY_CD1  = 0;
  localparam int SY_CD2  = 1;
  localparam int SY_ACK  = 2;
  localparam int SY_RDY  = 3;
  localparam int SY_IORDY = 4;
  localparam int SY_IO16 = 5;
  localparam int SY_W    = 6;
endpackage

// File: rtl/cf_sync2.sv
module cf_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  for (genvar i = 0; i < W; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        s1[i] <= RST_VAL[i];
        q[i]  <= RST_VAL[i];
      end else begin
        s1[i] <= d[i];
        q[i]  <= s1[i];
      end
    end
  end
endmodule

// File: rtl/cf_debounce.sv
module cf_debounce #(
  parameter int DEBOUNCE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic cd1_s,
  input  logic cd2_s,
  output logic present,
  output logic evt
);
  localparam int CW = (DEBOUNCE < 2) ? 1 : $clog2(DEBOUNCE + 1);
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE - 1);

  logic [CW-1:0] cnt;
  logic          raw;

  // seated only when both active-low pins are low
  assign raw = ~cd1_s & ~cd2_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      present <= 1'b0;
      evt     <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (raw == present) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        cnt     <= '0;
        present <= raw;
        evt     <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cf_mode_reg.sv
module cf_mode_reg
  import cf_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] mode_q,
  output logic              soft_rst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_RST;
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= 1'b0;
      if (wr) begin
        mode_q   <= wdata & MODE_WMASK;
        soft_rst <= wdata[MB_HEN] & ~mode_q[MB_HEN];
      end
    end
  end
endmodule

// File: rtl/cf_presence_ctrl.sv
module cf_presence_ctrl
  import cf_ctl_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DEBOUNCE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              cd1_n,
  input  logic              cd2_n,
  input  logic              card_ack,
  input  logic              card_rdy,
  input  logic              card_iordy,
  input  logic              card_io16,
  output logic              card_present,
  output logic              detect_evt,
  output logic              card_rst,
  output logic              card_hiz,
  output logic              host_en,
  output logic              dp_soft_rst,
  output logic [1:0]        mode_sel,
  output logic              card_plus,
  output logic              udma_en,
  output logic              mwdma_en,
  output logic [1:0]        drq_size
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_WA);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_WA);
  localparam logic [SY_W-1:0]   SY_RST = SY_W'(3);

  logic [SY_W-1:0]   pins_s;
  logic [REG_DW-1:0] mode_q;
  logic [REG_DW-1:0] status_w;
  logic              chg_q;
  logic              wr_mode;
  logic              wr_stat;

  assign wr_mode = reg_wr && (reg_addr == A_MODE);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);

  cf_sync2 #(.W(SY_W), .RST_VAL(SY_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({card_io16, card_iordy, card_rdy, card_ack, cd2_n, cd1_n}),
    .q   (pins_s)
  );

  cf_debounce #(.DEBOUNCE(DEBOUNCE)) u_deb (
    .clk     (clk),
    .rst     (rst),
    .cd1_s   (pins_s[SY_CD1]),
    .cd2_s   (pins_s[SY_CD2]),
    .present (card_present),
    .evt     (detect_evt)
  );

  cf_mode_reg u_mode (
    .clk      (clk),
    .rst      (rst),
    .wr       (wr_mode),
    .wdata    (reg_wdata),
    .mode_q   (mode_q),
    .soft_rst (dp_soft_rst)
  );

  // sticky presence-change flag; a new event wins over a clear
  always_ff @(posedge clk) begin
    if (rst)                           chg_q <= 1'b0;
    else if (detect_evt)               chg_q <= 1'b1;
    else if (wr_stat && reg_wdata[0])  chg_q <= 1'b0;
  end

  assign status_w = {23'd0, card_present, pins_s[SY_IO16], pins_s[SY_IORDY],
                     pins_s[SY_RDY], pins_s[SY_ACK], pins_s[SY_CD2],
                     pins_s[SY_CD1], 1'b0, chg_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_STAT:  reg_rdata <= status_w;
        A_MODE:  reg_rdata <= mode_q;
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign mode_sel  = mode_q[1:0];
  assign card_plus = mode_q[MB_TYPE];
  assign card_rst  = mode_q[MB_CRST];
  assign host_en   = mode_q[MB_HEN];
  assign card_hiz  = mode_q[MB_HIZ];
  assign udma_en   = mode_q[MB_UDMA];
  assign mwdma_en  = mode_q[MB_MWDMA];
  assign drq_size  = mode_q[MB_DRQ+1:MB_DRQ];
endmodule

// File: rtl/cf_presence_ctrl_chk.sv
module cf_presence_ctrl_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wr_bit3,
  input logic              card_rst,
  input logic              host_en,
  input logic              dp_soft_rst,
  input logic              card_present,
  input logic              detect_evt,
  input logic [1:0]        mode_sel,
  input logic [1:0]        drq_size
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(3);

  a_r8_rst_follows_write: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_MODE) |=> (card_rst == $past(wr_bit3)));

  a_r9_pulse_on_enable_rise: assert property (@(posedge clk) disable iff (rst)
    dp_soft_rst |-> (host_en && !$past(host_en)));

  a_r9_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    dp_soft_rst |=> !dp_soft_rst);

  a_r4_event_marks_change: assert property (@(posedge clk) disable iff (rst)
    detect_evt == (card_present != $past(card_present)));

  a_r7_mode_holds: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == A_MODE) |=>
      ($stable(mode_sel) && $stable(drq_size) && $stable(host_en) && $stable(card_rst)));
endmodule

bind cf_presence_ctrl cf_presence_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .wr_bit3      (reg_wdata[3]),
  .card_rst     (card_rst),
  .host_en      (host_en),
  .dp_soft_rst  (dp_soft_rst),
  .card_present (card_present),
  .detect_evt   (detect_evt),
  .mode_sel     (mode_sel),
  .drq_size     (drq_size)
);

// File: tb/tb_cf_presence_ctrl.sv
module tb_cf_presence_ctrl;
  localparam int ADDR_W = 4;
  localparam int DEB    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cd1_n = 1'b1, cd2_n = 1'b1;
  logic card_ack = 1'b0, card_rdy = 1'b0, card_iordy = 1'b0, card_io16 = 1'b0;
  logic card_present, detect_evt, card_rst, card_hiz, host_en, dp_soft_rst;
  logic [1:0] mode_sel, drq_size;
  logic card_plus, udma_en, mwdma_en;

  always #2.5 clk = ~clk;

  cf_presence_ctrl #(.ADDR_W(ADDR_W), .DEBOUNCE(DEB)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cd1_n(cd1_n), .cd2_n(cd2_n),
    .card_ack(card_ack), .card_rdy(card_rdy), .card_iordy(card_iordy),
    .card_io16(card_io16), .card_present(card_present), .detect_evt(detect_evt),
    .card_rst(card_rst), .card_hiz(card_hiz), .host_en(host_en),
    .dp_soft_rst(dp_soft_rst), .mode_sel(mode_sel), .card_plus(card_plus),
    .udma_en(udma_en), .mwdma_en(mwdma_en), .drq_size(drq_size)
  );

  typedef struct { string req; logic [31:0] val; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_fail = 0;
  logic rd_seen = 1'b0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: read data is due one edge after the strobe
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb.size() == 0) chk("SB", "unexpected read", reg_rdata, 32'h0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.req, "read data", reg_rdata, e.val);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] expv, input string req);
    exp_t e;
    e.req = req; e.val = expv;
    sb.push_back(e);
    reg_rd = 1'b1; reg_addr = ADDR_W'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    @(negedge clk);
  endtask

  // runs DEB+4 cycles after a pin change, checking the change point
  task automatic watch_change(input logic new_pres, input string req);
    int evts = 0;
    for (int i = 1; i <= DEB + 4; i++) begin
      @(negedge clk);
      if (detect_evt) evts++;
      if (i == DEB + 1) chk(req, "presence before window end", card_present, !new_pres);
      if (i == DEB + 2) begin
        chk(req, "presence at window end", card_present, new_pres);
        chk("R4", "event on change edge", detect_evt, 1'b1);
      end
    end
    chk("R4", "event count", evts, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int evts;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "card_rst", card_rst, 1'b1);
    chk("R1", "host_en", host_en, 1'b0);
    chk("R1", "present", card_present, 1'b0);
    chk("R1", "soft rst", dp_soft_rst, 1'b0);
    rd(3, 32'h8, "R1");
    rd(0, 32'h0C, "R1");

    // R6 pin levels appear after two edges
    card_ack = 1'b1; card_iordy = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(0, 32'h5C, "R6");
    card_ack = 1'b0; card_iordy = 1'b0; card_rdy = 1'b1; card_io16 = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(0, 32'hAC, "R6");
    card_rdy = 1'b0; card_io16 = 1'b0;

    // R2 only one pin low: never present
    cd1_n = 1'b0;
    evts = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (detect_evt) evts++; end
    chk("R2", "present with one pin", card_present, 1'b0);
    chk("R2", "no event with one pin", evts, 0);
    rd(0, 32'h08, "R2");

    // R3/R4 insertion
    cd2_n = 1'b0;
    watch_change(1'b1, "R3");
    rd(0, 32'h101, "R4");

    // R5 clear semantics
    wr(0, 32'h0000_0000);
    rd(0, 32'h101, "R5");
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h100, "R5");

    // R3 short glitch ignored
    cd2_n = 1'b1;
    repeat (DEB - 2) @(negedge clk);
    cd2_n = 1'b0;
    evts = 0;
    for (int i = 0; i < 3 * DEB; i++) begin @(negedge clk); if (detect_evt) evts++; end
    chk("R3", "presence after glitch", card_present, 1'b1);
    chk("R3", "no event on glitch", evts, 0);

    // R4 removal with one pin rising
    cd1_n = 1'b1;
    watch_change(1'b0, "R4");
    rd(0, 32'h105 & 32'h0FF, "R4");

    // R7 all-ones write, R9 enable rise
    wr(3, 32'hFFFF_FFFF);
    chk("R9", "pulse on enable rise", dp_soft_rst, 1'b1);
    chk("R7", "mode_sel", mode_sel, 2'd3);
    chk("R7", "fields", {card_plus, card_hiz, udma_en, mwdma_en, drq_size}, 6'b111111);
    chk("R8", "card_rst set", card_rst, 1'b1);
    @(negedge clk);
    chk("R9", "pulse one cycle", dp_soft_rst, 1'b0);
    rd(3, 32'h1B3F, "R7");

    // R9 no pulse when already enabled; R8 reset release
    wr(3, 32'h10);
    chk("R9", "no pulse when already on", dp_soft_rst, 1'b0);
    chk("R8", "card_rst cleared", card_rst, 1'b0);
    chk("R7", "tristate cleared", card_hiz, 1'b0);

    // R10 unmapped
    wr(5, 32'h0);
    chk("R10", "host_en after unmapped write", host_en, 1'b1);
    rd(3, 32'h10, "R10");
    rd(5, 32'h0, "R10");

    // R8 reset pulse by software
    wr(3, 32'h18);
    chk("R8", "card_rst asserted", card_rst, 1'b1);
    wr(3, 32'h10);
    chk("R8", "card_rst released", card_rst, 1'b0);

    // R9 disable then enable
    wr(3, 32'h0);
    chk("R9", "no pulse on disable", dp_soft_rst, 1'b0);
    wr(3, 32'h10);
    chk("R9", "pulse on re-enable", dp_soft_rst, 1'b1);

    // R7 individual fields
    wr(3, 32'h0802);
    chk("R7", "true-IDE mode", mode_sel, 2'd2);
    chk("R7", "drq 1024", drq_size, 2'd1);
    chk("R7", "host_en off", host_en, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7", "mode held", {mode_sel, drq_size}, 4'b1001);
    rd(3, 32'h0802, "R7");

    @(negedge clk);
    chk("SB", "queue drained", sb.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule